// File: doc/BRIEF.md
# Word-Add Execution Unit with Condition Flags

This execution unit adds a word-sized source operand to a destination value and produces both the new destination value and a set of seven condition flags. The destination is either a wide accumulator (a 4-bit extension nibble above two 16-bit words, 36 bits in all) or a plain 16-bit data register. The source is either a 16-bit word, which is sign-extended, or a 5-bit short immediate, which is zero-extended.

With an accumulator destination, the operand lands in the upper 20 bits of the accumulator: the extension nibble plus the most significant word. The add is a 20-bit operation there, and the low word passes through untouched. With a register destination, the add is a plain 16-bit operation.

The flags are sized to the destination. They report sign, zero, two's-complement overflow and carry. They also report whether the extension nibble holds significant bits and whether the result is unnormalized. A sticky limit flag records any overflow until an external clear input drops it. The result and the flags are registered on each clock edge where the execute strobe is high.

Top module: `wadd_unit`

## Requirements
- R1: Accumulator destination (dst_is_acc_i=1). A 16-bit source is sign-extended to 20 bits and added modulo 2^20 to dst_val_i[35:16]; the sum goes to dst_val_o[35:16]. dst_val_o[15:0] equals dst_val_i[15:0].
- R2: When src_is_imm_i=1, the 5-bit src_imm_i (value 0 to 31) is zero-extended and used in place of src_word_i, in both destination modes.
- R3: Register destination (dst_is_acc_i=0). dst_val_o[15:0] is (dst_val_i[15:0] + operand) mod 2^16, and dst_val_o[35:16] is zero.
- R4: N equals the result's most significant bit (bit 35 for an accumulator, bit 15 for a register). Z is set only when the whole result is zero: all 36 bits for an accumulator, 16 bits for a register.
- R5: V is set on two's-complement overflow of the add at its most significant bit (20-bit add for an accumulator, 16-bit add for a register). C is the carry out of that bit.
- R6: For an accumulator, E is set when result bits 35 to 31 are not all equal. For a register, E is always 0.
- R7: U is set when the two bits just below the extension are equal: bits 31 and 30 for an accumulator, bits 15 and 14 for a register.
- R8: L is sticky. It is set at any executed add with V=1 and stays set until a clock edge with lim_clr_i=1. If a clear and a setting add occur at the same edge, the set wins. A clear works whether or not exec_i is high.
- R9: Reset clears the result and all flags. On an edge with exec_i=0, dst_val_o and flags E, U, N, Z, V and C keep their values.
- R10: An accumulator holding 0x0_0058_1234 plus short immediate 3 gives 0x0_005B_1234, with N=Z=V=C=E=0 and U=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe; result and flags load on this edge |
| dst_is_acc_i | input | 1 | 1: 36-bit accumulator destination, 0: 16-bit register |
| src_is_imm_i | input | 1 | 1: use short immediate, 0: use 16-bit word |
| src_word_i | input | 16 | Word source operand (signed) |
| src_imm_i | input | 5 | Short immediate source (unsigned) |
| dst_val_i | input | 36 | Current destination value (register in bits 15:0) |
| lim_clr_i | input | 1 | Clears the sticky limit flag |
| dst_val_o | output | 36 | New destination value |
| flg_l_o | output | 1 | Sticky limit (overflow seen) |
| flg_e_o | output | 1 | Extension in use |
| flg_u_o | output | 1 | Unnormalized |
| flg_n_o | output | 1 | Negative |
| flg_z_o | output | 1 | Zero |
| flg_v_o | output | 1 | Overflow |
| flg_c_o | output | 1 | Carry |

## Verification
The bench builds the unit with its default widths: 16-bit words, a 4-bit extension and a 5-bit immediate. Because these are small, directed cases can reach every edge of the flag logic: the largest immediate of 31, the wrap at 0x7FFF, extension overflow at 20 bits, and zero results with and without a non-zero low word. The random phase mixes both destination modes, both source kinds, idle cycles and clear pulses. This brings out set-versus-clear collisions on the sticky flag and holds under changing inputs.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

   // Destination kind selected by dst_is_acc_i
   typedef enum logic {
      DST_REG = 1'b0,
      DST_ACC = 1'b1
   } wadd_dst_e;

   // Flags produced by one add (limit is kept apart, it is sticky)
   typedef struct packed {
      logic e;
      logic u;
      logic n;
      logic z;
      logic v;
      logic c;
   } wadd_flags_t;

   localparam wadd_flags_t FLAGS_CLR = '{e: 1'b0, u: 1'b0, n: 1'b0,
                                         z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/wadd_opnd_ext.sv
// Builds the OUT_W-bit addend: sign-extended word or zero-extended immediate.
module wadd_opnd_ext #(
   parameter int WORD_W = 16,
   parameter int IMM_W  = 5,
   parameter int OUT_W  = 20
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   output logic [OUT_W-1:0]  op_o
);
   localparam int WPAD = OUT_W - WORD_W;
   localparam int IPAD = OUT_W - IMM_W;

   logic [OUT_W-1:0] word_x;
   logic [OUT_W-1:0] imm_x;

   if (OUT_W < WORD_W) begin : g_bad_w
      $error("wadd_opnd_ext: OUT_W must be at least WORD_W");
   end
   if (IMM_W >= OUT_W) begin : g_bad_i
      $error("wadd_opnd_ext: IMM_W must be below OUT_W");
   end

   if (WPAD > 0) begin : g_word_sx
      assign word_x = {{WPAD{word_i[WORD_W-1]}}, word_i};
   end else begin : g_word_eq
      assign word_x = word_i;
   end

   assign imm_x = {{IPAD{1'b0}}, imm_i};

   assign op_o = use_imm_i ? imm_x : word_x;
endmodule

// File: rtl/wadd_adder.sv
// W-bit two's-complement adder with carry out and overflow.
module wadd_adder #(
   parameter int W = 20
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);
   logic [W:0] wide;

   if (W < 2) begin : g_bad
      $error("wadd_adder: W must be at least 2");
   end

   assign wide    = {1'b0, a_i} + {1'b0, b_i};
   assign sum_o   = wide[W-1:0];
   assign carry_o = wide[W];
   // Same operand signs, different result sign
   assign ovf_o   = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
endmodule

// File: rtl/wadd_flag_gen.sv
// Flag generation for one destination size. EXT_W = 0 means no extension
// field: the result is treated as already sign-extended.
module wadd_flag_gen
   import wadd_pkg::*;
#(
   parameter int W     = 20,
   parameter int EXT_W = 4
) (
   input  logic [W-1:0] sum_i,
   input  logic         carry_i,
   input  logic         ovf_i,
   input  logic         low_zero_i,
   output wadd_flags_t  flags_o
);
   localparam int MANT_MSB = W - EXT_W - 1;

   logic ext_used;
   logic unnorm;

   if (MANT_MSB < 1) begin : g_bad
      $error("wadd_flag_gen: too few bits below the extension");
   end

   if (EXT_W > 0) begin : g_ext
      logic [EXT_W:0] top;
      assign top      = sum_i[W-1:MANT_MSB];
      assign ext_used = !((top == '0) || (top == '1));
   end else begin : g_noext
      assign ext_used = 1'b0;
   end

   assign unnorm = (sum_i[MANT_MSB] == sum_i[MANT_MSB-1]);

   always_comb begin
      flags_o   = FLAGS_CLR;
      flags_o.e = ext_used;
      flags_o.u = unnorm;
      flags_o.n = sum_i[W-1];
      flags_o.z = (sum_i == '0) && low_zero_i;
      flags_o.v = ovf_i;
      flags_o.c = carry_i;
   end
endmodule

// File: rtl/wadd_unit.sv
// Word-add execution unit: accumulator / register destination, flag update.
module wadd_unit
   import wadd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int EXT_W  = 4,
   parameter int IMM_W  = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          exec_i,
   input  logic                          dst_is_acc_i,
   input  logic                          src_is_imm_i,
   input  logic [WORD_W-1:0]             src_word_i,
   input  logic [IMM_W-1:0]              src_imm_i,
   input  logic [EXT_W+2*WORD_W-1:0]     dst_val_i,
   input  logic                          lim_clr_i,
   output logic [EXT_W+2*WORD_W-1:0]     dst_val_o,
   output logic                          flg_l_o,
   output logic                          flg_e_o,
   output logic                          flg_u_o,
   output logic                          flg_n_o,
   output logic                          flg_z_o,
   output logic                          flg_v_o,
   output logic                          flg_c_o
);
   localparam int HI_W  = EXT_W + WORD_W;
   localparam int ACC_W = HI_W + WORD_W;

   if (WORD_W < 4) begin : g_bad_word
      $error("wadd_unit: WORD_W must be at least 4");
   end
   if (EXT_W < 1) begin : g_bad_ext
      $error("wadd_unit: EXT_W must be at least 1");
   end
   if (IMM_W < 1 || IMM_W >= WORD_W) begin : g_bad_imm
      $error("wadd_unit: IMM_W must lie in 1..WORD_W-1");
   end

   // Accumulator lane: 20-bit add on extension + high word
   logic [HI_W-1:0]   acc_op, acc_sum;
   logic              acc_c, acc_v;
   wadd_flags_t       acc_flags;
   logic [ACC_W-1:0]  acc_res;

   // Register lane: 16-bit add on the low word
   logic [WORD_W-1:0] reg_op, reg_sum;
   logic              reg_c, reg_v;
   wadd_flags_t       reg_flags;
   logic [ACC_W-1:0]  reg_res;

   wadd_opnd_ext #(.WORD_W(WORD_W), .IMM_W(IMM_W), .OUT_W(HI_W)) u_ext_acc (
      .word_i    (src_word_i),
      .imm_i     (src_imm_i),
      .use_imm_i (src_is_imm_i),
      .op_o      (acc_op)
   );

   wadd_opnd_ext #(.WORD_W(WORD_W), .IMM_W(IMM_W), .OUT_W(WORD_W)) u_ext_reg (
      .word_i    (src_word_i),
      .imm_i     (src_imm_i),
      .use_imm_i (src_is_imm_i),
      .op_o      (reg_op)
   );

   wadd_adder #(.W(HI_W)) u_add_acc (
      .a_i     (dst_val_i[ACC_W-1:WORD_W]),
      .b_i     (acc_op),
      .sum_o   (acc_sum),
      .carry_o (acc_c),
      .ovf_o   (acc_v)
   );

   wadd_adder #(.W(WORD_W)) u_add_reg (
      .a_i     (dst_val_i[WORD_W-1:0]),
      .b_i     (reg_op),
      .sum_o   (reg_sum),
      .carry_o (reg_c),
      .ovf_o   (reg_v)
   );

   wadd_flag_gen #(.W(HI_W), .EXT_W(EXT_W)) u_flg_acc (
      .sum_i      (acc_sum),
      .carry_i    (acc_c),
      .ovf_i      (acc_v),
      .low_zero_i (dst_val_i[WORD_W-1:0] == '0),
      .flags_o    (acc_flags)
   );

   wadd_flag_gen #(.W(WORD_W), .EXT_W(0)) u_flg_reg (
      .sum_i      (reg_sum),
      .carry_i    (reg_c),
      .ovf_i      (reg_v),
      .low_zero_i (1'b1),
      .flags_o    (reg_flags)
   );

   assign acc_res = {acc_sum, dst_val_i[WORD_W-1:0]};
   assign reg_res = {{HI_W{1'b0}}, reg_sum};

   // Destination-size select
   wadd_dst_e        dst_kind;
   logic [ACC_W-1:0] nxt_res;
   wadd_flags_t      nxt_flags;

   assign dst_kind = wadd_dst_e'(dst_is_acc_i);

   always_comb begin
      if (dst_kind == DST_ACC) begin
         nxt_res   = acc_res;
         nxt_flags = acc_flags;
      end else begin
         nxt_res   = reg_res;
         nxt_flags = reg_flags;
      end
   end

   // State
   logic [ACC_W-1:0] res_q;
   wadd_flags_t      flags_q;
   logic             lim_q;
   logic             lim_set;

   assign lim_set = exec_i && nxt_flags.v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_q <= FLAGS_CLR;
      end else if (exec_i) begin
         res_q   <= nxt_res;
         flags_q <= nxt_flags;
      end
   end

   // Sticky limit: set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= 1'b0;
      end else if (lim_set) begin
         lim_q <= 1'b1;
      end else if (lim_clr_i) begin
         lim_q <= 1'b0;
      end
   end

   assign dst_val_o = res_q;
   assign flg_l_o   = lim_q;
   assign flg_e_o   = flags_q.e;
   assign flg_u_o   = flags_q.u;
   assign flg_n_o   = flags_q.n;
   assign flg_z_o   = flags_q.z;
   assign flg_v_o   = flags_q.v;
   assign flg_c_o   = flags_q.c;
endmodule

// File: rtl/wadd_unit_chk.sv
// Property checker for wadd_unit, attached by bind below.
module wadd_unit_chk #(
   parameter int WORD_W = 16,
   parameter int EXT_W  = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      exec_i,
   input logic                      dst_is_acc_i,
   input logic [EXT_W+2*WORD_W-1:0] dst_val_i,
   input logic                      lim_clr_i,
   input logic [EXT_W+2*WORD_W-1:0] dst_val_o,
   input logic                      flg_l_o,
   input logic                      flg_e_o,
   input logic                      flg_n_o,
   input logic                      flg_z_o,
   input logic                      flg_v_o
);
   localparam int ACC_W = EXT_W + 2 * WORD_W;

   // R1: low word of an accumulator passes through
   assert_low_word_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && dst_is_acc_i |=> dst_val_o[WORD_W-1:0] == $past(dst_val_i[WORD_W-1:0]));

   // R3: register result leaves the upper bits clear
   assert_reg_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && !dst_is_acc_i |=> dst_val_o[ACC_W-1:WORD_W] == '0);

   // R4: N follows the result MSB for each size
   assert_neg_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && dst_is_acc_i |=> flg_n_o == dst_val_o[ACC_W-1]);
   assert_neg_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && !dst_is_acc_i |=> flg_n_o == dst_val_o[WORD_W-1]);

   // R4: Z for accumulator covers the whole 36 bits
   assert_zero_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && dst_is_acc_i |=> flg_z_o == (dst_val_o == '0));

   // R6: a register destination never reports extension in use
   assert_no_ext_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i && !dst_is_acc_i |=> !flg_e_o);

   // R8: L stays set while no clear arrives
   assert_lim_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flg_l_o && !lim_clr_i |=> flg_l_o);

   // R8: L only rises together with a fresh overflow
   assert_lim_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_l_o) |-> flg_v_o);

   // R9: idle edge keeps the result
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(dst_val_o));
endmodule

bind wadd_unit wadd_unit_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .exec_i       (exec_i),
   .dst_is_acc_i (dst_is_acc_i),
   .dst_val_i    (dst_val_i),
   .lim_clr_i    (lim_clr_i),
   .dst_val_o    (dst_val_o),
   .flg_l_o      (flg_l_o),
   .flg_e_o      (flg_e_o),
   .flg_n_o      (flg_n_o),
   .flg_z_o      (flg_z_o),
   .flg_v_o      (flg_v_o)
);

// File: tb/wadd_unit_tb.sv
module wadd_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        exec_i, dst_is_acc_i, src_is_imm_i, lim_clr_i;
   logic [15:0] src_word_i;
   logic [4:0]  src_imm_i;
   logic [35:0] dst_val_i;
   logic [35:0] dst_val_o;
   logic        flg_l_o, flg_e_o, flg_u_o, flg_n_o, flg_z_o, flg_v_o, flg_c_o;

   always #5 clk = ~clk;

   wadd_unit dut_i (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .dst_is_acc_i(dst_is_acc_i),
      .src_is_imm_i(src_is_imm_i), .src_word_i(src_word_i), .src_imm_i(src_imm_i),
      .dst_val_i(dst_val_i), .lim_clr_i(lim_clr_i), .dst_val_o(dst_val_o),
      .flg_l_o(flg_l_o), .flg_e_o(flg_e_o), .flg_u_o(flg_u_o), .flg_n_o(flg_n_o),
      .flg_z_o(flg_z_o), .flg_v_o(flg_v_o), .flg_c_o(flg_c_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Expected state
   logic [35:0] e_dst = '0;
   logic        e_l = 0, e_e = 0, e_u = 0, e_n = 0, e_z = 0, e_v = 0, e_c = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Reference: returns {dst[35:0], e, u, n, z, v, c}
   function automatic logic [41:0] model(input logic acc, input logic imm,
                                         input logic [15:0] w, input logic [4:0] iv,
                                         input logic [35:0] d);
      longint sop, sa, s, ua, uop, us;
      logic [19:0] r20;
      logic [15:0] r16;
      logic e, u, n, z, v, c;
      logic [35:0] res;
      sop = imm ? longint'(iv) : longint'($signed(w));
      if (acc) begin
         sa  = longint'($signed(d[35:16]));
         s   = sa + sop;
         v   = (s > 524287) || (s < -524288);
         ua  = longint'(d[35:16]);
         uop = sop & 64'hFFFFF;
         us  = ua + uop;
         c   = us >= 64'h100000;
         r20 = us[19:0];
         e   = (r20[19:15] != 5'h00) && (r20[19:15] != 5'h1f);
         u   = r20[15] == r20[14];
         n   = r20[19];
         z   = (r20 == 20'h0) && (d[15:0] == 16'h0);
         res = {r20, d[15:0]};
      end else begin
         sa  = longint'($signed(d[15:0]));
         s   = sa + sop;
         v   = (s > 32767) || (s < -32768);
         ua  = longint'(d[15:0]);
         uop = sop & 64'hFFFF;
         us  = ua + uop;
         c   = us >= 64'h10000;
         r16 = us[15:0];
         e   = 1'b0;
         u   = r16[15] == r16[14];
         n   = r16[15];
         z   = r16 == 16'h0;
         res = {20'h0, r16};
      end
      return {res, e, u, n, z, v, c};
   endfunction

   task automatic check_all(input string dtag);
      chk(dtag,  64'(dst_val_o), 64'(e_dst));
      chk("R4 N", 64'(flg_n_o), 64'(e_n));
      chk("R4 Z", 64'(flg_z_o), 64'(e_z));
      chk("R5 V", 64'(flg_v_o), 64'(e_v));
      chk("R5 C", 64'(flg_c_o), 64'(e_c));
      chk("R6 E", 64'(flg_e_o), 64'(e_e));
      chk("R7 U", 64'(flg_u_o), 64'(e_u));
      chk("R8 L", 64'(flg_l_o), 64'(e_l));
   endtask

   task automatic step(input logic ex, input logic acc, input logic imm,
                       input logic [15:0] w, input logic [4:0] iv,
                       input logic [35:0] d, input logic clr, input string dtag);
      logic [41:0] m;
      @(negedge clk);
      exec_i = ex; dst_is_acc_i = acc; src_is_imm_i = imm;
      src_word_i = w; src_imm_i = iv; dst_val_i = d; lim_clr_i = clr;
      m = model(acc, imm, w, iv, d);
      if (ex) begin
         {e_dst, e_e, e_u, e_n, e_z, e_v, e_c} = m;
         if (m[1]) e_l = 1'b1;
         else if (clr) e_l = 1'b0;
      end else if (clr) begin
         e_l = 1'b0;
      end
      @(posedge clk);
      #2;
      check_all(dtag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      rst_n = 1'b0; exec_i = 0; dst_is_acc_i = 0; src_is_imm_i = 0;
      src_word_i = '0; src_imm_i = '0; dst_val_i = '0; lim_clr_i = 0;
      repeat (3) @(posedge clk);
      #2;
      check_all("R9 reset dst");
      @(negedge clk); rst_n = 1'b1;

      // R10: the worked example, accumulator plus immediate 3
      step(1, 1, 1, 16'hFFFF, 5'd3, 36'h0_0058_1234, 0, "R10 example");
      chk("R10 U", 64'(flg_u_o), 64'd1);
      // R2: immediate 31 zero-extended, accumulator and register
      step(1, 1, 1, 16'h8000, 5'd31, 36'h0_0000_0000, 0, "R2 imm acc");
      chk("R2 imm31 acc", 64'(dst_val_o), 64'h0_001F_0000);
      step(1, 0, 1, 16'h8000, 5'd31, 36'h0_0000_FFF0, 0, "R2 imm reg");
      chk("R2 imm31 reg", 64'(dst_val_o), 64'h0_0000_000F);
      // R1: negative word sign-extended into extension
      step(1, 1, 0, 16'hFFFF, 5'd0, 36'h0_0000_ABCD, 0, "R1 sext");
      chk("R1 sext", 64'(dst_val_o), 64'hF_FFFF_ABCD);
      // R6: extension in use after crossing bit 31
      step(1, 1, 0, 16'h0001, 5'd0, 36'h0_7FFF_0000, 0, "R6 ext");
      chk("R6 ext used", 64'(flg_e_o), 64'd1);
      // R5, R8: 20-bit overflow sets V and L
      step(1, 1, 0, 16'h0001, 5'd0, 36'h7_FFFF_0000, 0, "R5 acc ovf");
      chk("R8 L set", 64'(flg_l_o), 64'd1);
      // R9: idle edge with different inputs holds everything
      step(0, 0, 0, 16'h1234, 5'd7, 36'h0_0000_0001, 0, "R9 hold");
      // R8: clear without exec
      step(0, 1, 0, 16'h0000, 5'd0, 36'h0, 1, "R8 clr");
      chk("R8 L clr", 64'(flg_l_o), 64'd0);
      // R3, R5: register wrap 0x7FFF+1, set beats clear
      step(1, 0, 0, 16'h0001, 5'd0, 36'hF_FFFF_7FFF, 1, "R3 wrap");
      chk("R8 set wins", 64'(flg_l_o), 64'd1);
      // R4: accumulator with zero upper but non-zero low word
      step(1, 1, 0, 16'h0001, 5'd0, 36'hF_FFFF_0001, 1, "R4 low nz");
      chk("R4 Z low nz", 64'(flg_z_o), 64'd0);
      step(1, 1, 0, 16'h0001, 5'd0, 36'hF_FFFF_0000, 0, "R4 all zero");
      chk("R4 Z zero", 64'(flg_z_o), 64'd1);
      // R5: register carry without overflow
      step(1, 0, 0, 16'hFFFF, 5'd0, 36'h0_0000_0001, 0, "R5 carry");
      chk("R5 C reg", 64'(flg_c_o), 64'd1);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic [35:0] d;
         logic ex, acc, imm, clr;
         d   = {4'($urandom), 32'($urandom)};
         ex  = ($urandom % 8) != 0;
         acc = 1'($urandom);
         imm = ($urandom % 4) == 0;
         clr = ($urandom % 6) == 0;
         if (($urandom % 5) == 0) d[35:16] = {20{d[35]}};
         step(ex, acc, imm, 16'($urandom), 5'($urandom), d, clr,
              acc ? "R1 rand" : "R3 rand");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule